// File: doc/BRIEF.md
# Multi-Channel Match Timer

This block is an operating-system timer peripheral. A 32-bit counter advances by one on each pulse of a tick-enable input and wraps freely through its whole range. Four compare channels each hold a 32-bit target value. When the counter lands on a channel's target, that channel's sticky status flag is latched. An interrupt line for the channel is asserted while the flag is set and the channel is enabled.

Software uses a single-cycle register bus. The write takes effect at the next clock edge, and the read data is combinational from the address. Through this bus software reprograms targets, clears flags by writing ones, gates the interrupt lines, and overwrites the counter directly. This lets a kernel schedule periodic ticks relative to a counter that wraps.

Register map, by byte address: target n sits at 0x00 + 4n for n = 0..3. The counter is at 0x10, the status flags at 0x14 (bit n belongs to channel n) and the enables at 0x1C (bit n belongs to channel n).

Top module: `match_timer`

## Requirements
- R1: After synchronous reset, the counter, every target, the status flags and the enables are zero, and every interrupt line is low.
- R2: The counter increases by one at each clock edge where `tick_en` is high, keeps its value when `tick_en` is low, and goes from 0xFFFFFFFF to 0 with no saturation.
- R3: A write to 0x10 loads the counter, and the new value is readable after the next edge. If a tick arrives in the same cycle, the write wins.
- R4: A write to 0x00 + 4n replaces target n at any time, and a read of that address returns it.
- R5: Take the edge at which the counter takes a value equal to target n, whether by tick or by write. Status bit n (bit n of 0x14) is set at the following edge, whether or not channel n is enabled.
- R6: Writing a 1 to bit n of 0x14 clears status bit n. Bits written as 0 are unchanged, so writing 0 does nothing and writing 0xF clears all four.
- R7: If a set from a match and a clear from a write meet on the same status bit in the same cycle, the bit ends set.
- R8: The compare is evaluated only in the cycle after the counter was updated. A counter that stays on a target sets the flag once, and the flag stays clear after software clears it.
- R9: `irq[n]` is high exactly when status bit n and enable bit n (bit n of 0x1C) are both set. Enabling a channel whose flag is already set raises its line at once.
- R10: An interrupt line stays high until its flag is cleared or its enable is removed.
- R11: Reads of unused addresses (such as 0x18) return zero. The status and enable reads are zero above bit 3, and enable bits above bit 3 are ignored when written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle counter advance pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
Two functions can hit the same status bit in one cycle: the latch of a match and a write-one-to-clear from software. To provoke this, the bench programs a target and then loads the counter with that value. In the next cycle, which is the cycle the compare fires, it writes a 1 to the matching status bit, and then reads the flag back, expecting it to be set. A counter write that coincides with a tick is also provoked, and the outcome is judged by reading the counter. In the random phase, writes land on top of ticks and matches freely, and every cycle is compared against a model in the bench.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
    localparam int DATA_W   = 32;
    localparam int CHANNELS = 4;
    localparam int BUS_AW   = 5;

    // byte offsets of the non-target registers
    localparam int OFS_COUNT  = 'h10;
    localparam int OFS_STATUS = 'h14;
    localparam int OFS_GAP    = 'h18;
    localparam int OFS_ENABLE = 'h1C;

    typedef struct packed {
        logic cnt_load;
        logic stat_wr;
        logic en_wr;
    } wr_ctl_t;

    function automatic int target_ofs(input int ch);
        return ch * 4;
    endfunction
endpackage

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
    parameter int CNT_W = mtmr_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             upd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= load | tick_en;
            if (load)
                cnt_q <= load_val;
            else if (tick_en)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel #(
    parameter int CNT_W = mtmr_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tgt_wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_upd,
    input  logic             clr,
    output logic [CNT_W-1:0] tgt_q,
    output logic             flag_q,
    output logic             hit
);
    // compare only right after the counter moved
    assign hit = cnt_upd && (cnt == tgt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (tgt_wr)
                tgt_q <= wr_val;
            flag_q <= hit | (flag_q & ~clr);
        end
    end
endmodule

// File: rtl/mtmr_regif.sv
module mtmr_regif #(
    parameter int CNT_W  = mtmr_pkg::DATA_W,
    parameter int NUM_CH = mtmr_pkg::CHANNELS,
    parameter int ADDR_W = mtmr_pkg::BUS_AW
) (
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NUM_CH-1:0][CNT_W-1:0] tgt_all,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [NUM_CH-1:0]            flags,
    input  logic [NUM_CH-1:0]            enables,
    output mtmr_pkg::wr_ctl_t            ctl,
    output logic [NUM_CH-1:0]            tgt_wr,
    output logic [CNT_W-1:0]             rd_data
);
    import mtmr_pkg::*;

    always_comb begin
        ctl.cnt_load = wr_en && (addr == ADDR_W'(OFS_COUNT));
        ctl.stat_wr  = wr_en && (addr == ADDR_W'(OFS_STATUS));
        ctl.en_wr    = wr_en && (addr == ADDR_W'(OFS_ENABLE));
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
        assign tgt_wr[n] = wr_en && (addr == ADDR_W'(target_ofs(n)));
    end

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NUM_CH; n++)
            if (addr == ADDR_W'(target_ofs(n)))
                rd_data = tgt_all[n];
        if (addr == ADDR_W'(OFS_COUNT))
            rd_data = cnt;
        if (addr == ADDR_W'(OFS_STATUS))
            rd_data = CNT_W'(flags);
        if (addr == ADDR_W'(OFS_ENABLE))
            rd_data = CNT_W'(enables);
    end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
    parameter int CNT_W  = mtmr_pkg::DATA_W,
    parameter int NUM_CH = mtmr_pkg::CHANNELS,
    parameter int ADDR_W = mtmr_pkg::BUS_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NUM_CH-1:0] irq
);
    mtmr_pkg::wr_ctl_t            ctl;
    logic [NUM_CH-1:0]            tgt_wr;
    logic [NUM_CH-1:0][CNT_W-1:0] tgt_all;
    logic [NUM_CH-1:0]            status_q;
    logic [NUM_CH-1:0]            hit_vec;
    logic [NUM_CH-1:0]            en_q;
    logic [CNT_W-1:0]             cnt_q;
    logic                         upd_q;

    mtmr_regif #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regif (
        .wr_en   (wr_en),
        .addr    (addr),
        .tgt_all (tgt_all),
        .cnt     (cnt_q),
        .flags   (status_q),
        .enables (en_q),
        .ctl     (ctl),
        .tgt_wr  (tgt_wr),
        .rd_data (rd_data)
    );

    mtmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load     (ctl.cnt_load),
        .load_val (wr_data),
        .cnt_q    (cnt_q),
        .upd_q    (upd_q)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        mtmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tgt_wr  (tgt_wr[n]),
            .wr_val  (wr_data),
            .cnt     (cnt_q),
            .cnt_upd (upd_q),
            .clr     (ctl.stat_wr && wr_data[n]),
            .tgt_q   (tgt_all[n]),
            .flag_q  (status_q[n]),
            .hit     (hit_vec[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (ctl.en_wr)
            en_q <= wr_data[NUM_CH-1:0];
    end

    assign irq = status_q & en_q;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
    parameter int CNT_W  = mtmr_pkg::DATA_W,
    parameter int NUM_CH = mtmr_pkg::CHANNELS,
    parameter int ADDR_W = mtmr_pkg::BUS_AW
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic [CNT_W-1:0]  rd_data,
    input logic [NUM_CH-1:0] irq,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [NUM_CH-1:0] status_q,
    input logic [NUM_CH-1:0] hit_vec
);
    import mtmr_pkg::*;

    logic cnt_wr, stat_wr, en_wr;
    assign cnt_wr  = wr_en && (addr == ADDR_W'(OFS_COUNT));
    assign stat_wr = wr_en && (addr == ADDR_W'(OFS_STATUS));
    assign en_wr   = wr_en && (addr == ADDR_W'(OFS_ENABLE));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cnt_wr) |=> $stable(cnt_q));

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == $past(wr_data)));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|hit_vec) |=> ((status_q & $past(hit_vec)) == $past(hit_vec)));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_wr && !en_wr) |=> ((irq & $past(irq)) == $past(irq)));

    // R11
    gap_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(OFS_GAP)) |-> (rd_data == '0));
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq      (irq),
    .cnt_q    (cnt_q),
    .status_q (status_q),
    .hit_vec  (hit_vec)
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench reference state
    logic [31:0] m_cnt;
    logic        m_upd;
    logic [31:0] m_tgt [4];
    logic [3:0]  m_stat;
    logic [3:0]  m_en;

    match_timer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_tgt[0];
            5'h04: return m_tgt[1];
            5'h08: return m_tgt[2];
            5'h0C: return m_tgt[3];
            5'h10: return m_cnt;
            5'h14: return {28'd0, m_stat};
            5'h1C: return {28'd0, m_en};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a < 5'h10 && a[1:0] == 2'b00) return "R4";
        if (a == 5'h10) return "R2";
        if (a == 5'h14) return "R5";
        if (a == 5'h1C) return "R9";
        return "R11";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_cnt = '0; m_upd = 1'b0; m_stat = '0; m_en = '0;
        for (int n = 0; n < 4; n++) m_tgt[n] = '0;
    endtask

    // one bus cycle; compares read data and irq at the falling edge
    task automatic cyc(input string tag, input bit w, input logic [4:0] a,
                       input logic [31:0] d, input bit tk);
        logic [3:0]  hit;
        logic [3:0]  clr;
        wr_en = w; addr = a; wr_data = d; tick_en = tk;
        @(posedge clk);
        for (int n = 0; n < 4; n++) hit[n] = m_upd && (m_cnt == m_tgt[n]);
        clr = (w && a == 5'h14) ? d[3:0] : 4'd0;
        m_stat = hit | (m_stat & ~clr);
        m_upd  = (w && a == 5'h10) || tk;
        if (w && a == 5'h10) m_cnt = d;
        else if (tk) m_cnt = m_cnt + 32'd1;
        if (w && a < 5'h10 && a[1:0] == 2'b00) m_tgt[a[3:2]] = d;
        if (w && a == 5'h1C) m_en = d[3:0];
        @(negedge clk);
        chk(tag, rd_data, m_read(a));
        chk("R9", {28'd0, irq}, {28'd0, m_stat & m_en});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", {28'd0, irq}, 32'd0);
        cyc("R1", 0, 5'h10, 0, 0);  chk("R1", rd_data, 32'd0);
        cyc("R1", 0, 5'h14, 0, 0);  chk("R1", rd_data, 32'd0);
        cyc("R1", 0, 5'h1C, 0, 0);  chk("R1", rd_data, 32'd0);
        cyc("R1", 0, 5'h0C, 0, 0);  chk("R1", rd_data, 32'd0);

        // R2 wrap, R3 load
        cyc("R3", 1, 5'h10, 32'hFFFF_FFFE, 0);
        cyc("R2", 0, 5'h10, 0, 1);  chk("R2", rd_data, 32'hFFFF_FFFF);
        cyc("R2", 0, 5'h10, 0, 1);  chk("R2", rd_data, 32'h0000_0000);
        // counter reached 0 == every target; flags latch at the next edge
        cyc("R2", 0, 5'h10, 0, 0);  chk("R2", rd_data, 32'h0000_0000);
        cyc("R5", 0, 5'h14, 0, 0);  chk("R5", rd_data, 32'hF);
        cyc("R6", 1, 5'h14, 32'hF, 0);
        // R8 held counter on target: no refire
        cyc("R8", 0, 5'h14, 0, 0);  chk("R8", rd_data, 32'd0);
        cyc("R8", 0, 5'h14, 0, 0);  chk("R8", rd_data, 32'd0);

        // R3 write beats a simultaneous tick
        cyc("R3", 1, 5'h10, 32'h50, 1);
        cyc("R3", 0, 5'h10, 0, 0);  chk("R3", rd_data, 32'h50);

        // R4 target write and readback
        cyc("R4", 1, 5'h04, 32'h55, 0);
        cyc("R4", 0, 5'h04, 0, 0);  chk("R4", rd_data, 32'h55);

        // R5 match on channel 1 by ticking up to 0x55
        for (int k = 0; k < 5; k++) cyc("R5", 0, 5'h14, 0, 1);
        chk("R5", rd_data, 32'd0);
        cyc("R5", 0, 5'h14, 0, 0);  chk("R5", rd_data, 32'h2);
        chk("R9", {28'd0, irq}, 32'd0);

        // R9 pending flag appears when enabled
        cyc("R9", 1, 5'h1C, 32'h3, 0); chk("R9", {28'd0, irq}, 32'h2);
        cyc("R9", 1, 5'h1C, 32'h0, 0); chk("R9", {28'd0, irq}, 32'h0);
        cyc("R9", 1, 5'h1C, 32'h3, 0); chk("R9", {28'd0, irq}, 32'h2);

        // R10 held across ticks
        for (int k = 0; k < 4; k++) cyc("R10", 0, 5'h10, 0, 1);
        chk("R10", {28'd0, irq}, 32'h2);

        // R6 write-one-to-clear
        cyc("R6", 1, 5'h14, 32'h0, 0); chk("R6", {28'd0, irq}, 32'h2);
        cyc("R6", 1, 5'h14, 32'h1, 0); chk("R6", {28'd0, irq}, 32'h2);
        cyc("R6", 1, 5'h14, 32'h2, 0); chk("R6", {28'd0, irq}, 32'h0);

        // R7 set and clear collide on channel 0
        cyc("R7", 1, 5'h00, 32'h100, 0);
        cyc("R7", 1, 5'h10, 32'h100, 0);
        cyc("R7", 1, 5'h14, 32'h1, 0);
        cyc("R7", 0, 5'h14, 0, 0);  chk("R7", rd_data, 32'h1);
        cyc("R7", 1, 5'h14, 32'h1, 0);
        cyc("R7", 0, 5'h14, 0, 0);  chk("R7", rd_data, 32'h0);

        // R11 unused offset and enable width
        cyc("R11", 0, 5'h18, 0, 0); chk("R11", rd_data, 32'd0);
        cyc("R11", 1, 5'h1C, 32'hFFFF_FFF5, 0);
        cyc("R11", 0, 5'h1C, 0, 0); chk("R11", rd_data, 32'h5);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [4:0]  a;
            logic [31:0] d;
            bit          w;
            a = 5'($urandom_range(0, 7) * 4);
            w = ($urandom_range(0, 9) < 3);
            case (a)
                5'h10:   d = ($urandom_range(0, 15) == 0) ? 32'hFFFF_FFF8 : 32'($urandom_range(0, 63));
                5'h14,
                5'h1C:   d = $urandom;
                default: d = 32'($urandom_range(0, 63));
            endcase
            cyc(tag_of(a), w, a, d, $urandom_range(0, 1) == 1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule